// File: doc/BRIEF.md
# Supervisory Reset and Pushbutton Controller

This block is the digital half of a power-on and pushbutton reset supervisor. External comparators judge each supply rail and hand it a set of supply-good flags, which are already synchronous to the system clock. From those flags and a single active-low pushbutton it produces a hard reset, driven as an active-low line with an active-high copy, and a separate active-low soft-reset pulse.

Any bad supply holds the hard reset at once. Once every rail is good again, the reset is held a little longer (a stretch of a fixed number of cycles) so the rails can settle. The pushbutton is sorted by how long it is held. A brief press asks for a soft reset, and the pulse is sent when the button is let go. A press that reaches the long-press threshold forces the hard reset instead, and the reset is released only once the stretch has run after the button is let go. Every delay is a cycle-count parameter. The defaults are derived from a clock frequency: a 2 s long-press threshold, a 200 ms stretch and a 100 µs soft pulse.

Top module: `rst_supervisor`

## Requirements
- R1: `hrst_n` is low in every cycle in which any bit of `sup_ok` is 0, starting in the same cycle as the bad bit.
- R2: Once all `sup_ok` bits are 1 and no long press is in force, `hrst_n` stays low for exactly STRETCH_CYC more rising edges. It goes high after the STRETCH_CYC-th edge.
- R3: `btn_n` passes through a two-flop synchronizer. Each rising edge that sees the synchronized button low, with all supplies good, adds one to the press length. When the press length reaches LONG_CYC, `hrst_n` goes low and stays low while the button is held. After release it stays low for the R2 stretch, which counts from the edge that sees the synchronized release.
- R4: A press whose length lies between 1 and LONG_CYC-1 causes no hard reset. When it is released, `srst_n` goes low after the third rising edge following the rise of `btn_n` and stays low for exactly PULSE_CYC cycles.
- R5: `hrst` is always the logical inverse of `hrst_n`.
- R6: A press that reaches LONG_CYC produces no soft pulse when it is released.
- R7: If any supply goes bad while a soft pulse is running, `srst_n` returns high in that same cycle and the pulse is dropped.
- R8: The stretch restarts from zero whenever a supply goes bad again, or a new long press takes effect, before the stretch has finished.
- R9: While any supply is bad, button activity is ignored. Its press length is held at zero, so a press made and released within a fault produces neither a soft pulse nor a long-press hold.
- R10: While `arst_n` is low, `hrst_n` is 0, `hrst` is 1 and `srst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low system reset |
| sup_ok | input | NUM_SUP | Supply-good flags, already synchronous, 1 = good |
| btn_n | input | 1 | Pushbutton, active low, idle high, asynchronous |
| hrst_n | output | 1 | Hard reset, active low |
| hrst | output | 1 | Hard reset, active high |
| srst_n | output | 1 | Soft-reset pulse, active low |

## Verification
The bench builds the block with LONG_CYC=40, STRETCH_CYC=16 and PULSE_CYC=6 in place of the multi-second defaults. With these values, several complete long presses, stretch restarts and soft pulses fit into a few thousand cycles. The short cycle counts also let random press lengths land on both sides of the long-press threshold, including one cycle below it and exactly on it. They also let supply glitches fall inside a running soft pulse or part-way through a stretch.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  // Convert a duration to clock cycles from the clock rate in kHz.
  function automatic int unsigned ms_to_cyc(int unsigned clk_khz, int unsigned ms);
    return clk_khz * ms;
  endfunction

  function automatic int unsigned us_to_cyc(int unsigned clk_khz, int unsigned us);
    return (clk_khz * us) / 1000;
  endfunction

  // Width of a counter that must hold the value n.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rsup_sync2.sv
module rsup_sync2 #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain[i] <= IDLE;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsup_press_class.sv
module rsup_press_class
  import rsup_pkg::*;
#(
  parameter int unsigned LONG_CYC = 40
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pressed,     // synchronized, active high
  input  logic sup_bad,
  output logic long_hold,   // long press in force
  output logic short_rel    // released after a short press (event)
);
  localparam int unsigned CW = cnt_width(LONG_CYC);
  localparam logic [CW-1:0] LAST = CW'(LONG_CYC - 1);

  logic [CW-1:0] len_q;
  logic          long_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      len_q  <= '0;
      long_q <= 1'b0;
    end else if (sup_bad || !pressed) begin
      len_q  <= '0;
      long_q <= 1'b0;
    end else begin
      if (len_q == LAST) long_q <= 1'b1;
      else len_q <= len_q + 1'b1;
    end
  end

  assign long_hold = long_q;
  assign short_rel = !pressed && !sup_bad && (len_q != '0) && !long_q;

  // R9: a bad supply leaves no press state behind
  a_r9_fault_clears_press: assert property (@(posedge clk) disable iff (!arst_n)
    sup_bad |=> (len_q == '0) && !long_q);
  // R6: a release after a long press never counts as short
  a_r6_long_not_short: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(long_q) |-> !$past(short_rel));
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch
  import rsup_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  output logic active
);
  localparam int unsigned CW = cnt_width(STRETCH_CYC);
  localparam logic [CW-1:0] DONE = CW'(STRETCH_CYC);

  logic [CW-1:0] run_q;
  logic          done;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       run_q <= '0;
    else if (hold)     run_q <= '0;
    else if (!done)    run_q <= run_q + 1'b1;
  end

  assign done   = (run_q == DONE);
  assign active = hold || !done;

  // R2: release only after the full count with no hold
  a_r2_release_after_count: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(active) |-> ($past(run_q) == CW'(STRETCH_CYC - 1)) && !$past(hold));
  // R8: any hold restarts the count
  a_r8_hold_restarts: assert property (@(posedge clk) disable iff (!arst_n)
    hold |=> (run_q == '0));
endmodule

// File: rtl/rsup_soft_pulse.sv
module rsup_soft_pulse
  import rsup_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 6
) (
  input  logic clk,
  input  logic arst_n,
  input  logic fire,
  input  logic cancel,
  output logic active
);
  localparam int unsigned CW = cnt_width(PULSE_CYC);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              left_q <= '0;
    else if (cancel)          left_q <= '0;
    else if (fire)            left_q <= CW'(PULSE_CYC);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0) && !cancel;

  // R4: a pulse begins with a full load
  a_r4_full_load: assert property (@(posedge clk) disable iff (!arst_n)
    (fire && !cancel) |=> (left_q == CW'(PULSE_CYC)));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int unsigned NUM_SUP     = 3,
  parameter int unsigned CLK_KHZ     = 125000,
  parameter int unsigned LONG_CYC    = ms_to_cyc(CLK_KHZ, 2000),
  parameter int unsigned STRETCH_CYC = ms_to_cyc(CLK_KHZ, 200),
  parameter int unsigned PULSE_CYC   = us_to_cyc(CLK_KHZ, 100)
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [NUM_SUP-1:0] sup_ok,
  input  logic               btn_n,
  output logic               hrst_n,
  output logic               hrst,
  output logic               srst_n
);
  logic btn_s;
  logic pressed;
  logic sup_bad;
  logic long_hold;
  logic short_rel;
  logic hard_hold;
  logic hard_act;
  logic soft_act;

  assign sup_bad = !(&sup_ok);

  rsup_sync2 #(.STAGES(2), .IDLE(1'b1)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(btn_n), .q(btn_s)
  );
  assign pressed = !btn_s;

  rsup_press_class #(.LONG_CYC(LONG_CYC)) u_press (
    .clk(clk), .arst_n(arst_n), .pressed(pressed), .sup_bad(sup_bad),
    .long_hold(long_hold), .short_rel(short_rel)
  );

  assign hard_hold = sup_bad || long_hold;

  rsup_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk(clk), .arst_n(arst_n), .hold(hard_hold), .active(hard_act)
  );

  rsup_soft_pulse #(.PULSE_CYC(PULSE_CYC)) u_soft (
    .clk(clk), .arst_n(arst_n), .fire(short_rel), .cancel(sup_bad),
    .active(soft_act)
  );

  assign hrst_n = !hard_act;
  assign hrst   = hard_act;
  assign srst_n = !soft_act;

  // R1: a bad supply always shows as a hard reset
  a_r1_fault_resets: assert property (@(posedge clk) disable iff (!arst_n)
    sup_bad |-> !hrst_n);
  // R5: the two hard reset outputs are complementary
  a_r5_complement: assert property (@(posedge clk) disable iff (!arst_n)
    hrst == !hrst_n);
  // R7: a bad supply silences the soft pulse
  a_r7_fault_kills_soft: assert property (@(posedge clk) disable iff (!arst_n)
    sup_bad |-> srst_n);
  // R3: a long press holds the hard reset
  a_r3_long_holds: assert property (@(posedge clk) disable iff (!arst_n)
    long_hold |-> !hrst_n);
endmodule

// File: tb/rst_supervisor_tb.sv
`timescale 1ns/1ps
module rst_supervisor_tb;
  localparam int unsigned NS = 3;
  localparam int LONG = 40;
  localparam int STR  = 16;
  localparam int PUL  = 6;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [NS-1:0] sup_ok = '0;
  logic btn_n = 1'b1;
  logic hrst_n, hrst, srst_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  always #4 clk = ~clk;

  rst_supervisor #(.NUM_SUP(NS), .LONG_CYC(LONG), .STRETCH_CYC(STR), .PULSE_CYC(PUL)) u_dut (
    .clk(clk), .arst_n(arst_n), .sup_ok(sup_ok), .btn_n(btn_n),
    .hrst_n(hrst_n), .hrst(hrst), .srst_n(srst_n)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Reference model built from the requirements: press length, time since
  // the last hold, and remaining soft-pulse cycles.
  logic m_s1 = 1'b1, m_s2 = 1'b1;
  int   m_len = 0;
  int   m_since = 0;
  int   m_left = 0;

  function automatic bit any_bad(logic [NS-1:0] s);
    return s != '1;
  endfunction
  function automatic bit exp_hard(logic [NS-1:0] s, int len, int since);
    return any_bad(s) || (len >= LONG) || (since < STR);
  endfunction
  function automatic bit exp_soft(logic [NS-1:0] s, int left);
    return !any_bad(s) && (left > 0);
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_len <= 0; m_since <= 0; m_left <= 0;
    end else begin
      bit bad, held, short_r;
      bad     = any_bad(sup_ok);
      held    = bad || (m_len >= LONG);
      short_r = !bad && m_s2 && (m_len > 0) && (m_len < LONG);
      m_s1 <= btn_n;
      m_s2 <= m_s1;
      if (bad || m_s2) m_len <= 0;
      else m_len <= m_len + 1;
      if (held) m_since <= 0;
      else if (m_since < STR) m_since <= m_since + 1;
      if (bad) m_left <= 0;
      else if (short_r) m_left <= PUL;
      else if (m_left > 0) m_left <= m_left - 1;
    end
  end

  always @(negedge clk) begin
    #2;
    if (live && arst_n) begin
      chk("R2", hrst_n, !exp_hard(sup_ok, m_len, m_since));
      chk("R4", srst_n, !exp_soft(sup_ok, m_left));
      chk("R5", hrst, !hrst_n);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic smp();
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    bit soft_seen;
    seed = 7;
    void'($urandom(seed));
    // R10 reset state
    step(2); smp();
    chk("R10", hrst_n, 1'b0); chk("R10", hrst, 1'b1); chk("R10", srst_n, 1'b1);
    step(1); arst_n = 1'b1; live = 1;
    step(3); smp();
    chk("R1", hrst_n, 1'b0);
    // R2 exact stretch
    step(1); sup_ok = '1;
    step(STR - 1); smp(); chk("R2", hrst_n, 1'b0);
    step(1); smp(); chk("R2", hrst_n, 1'b1);
    // R1 single rail fault
    step(3); sup_ok = 3'b101; smp(); chk("R1", hrst_n, 1'b0);
    step(1); sup_ok = '1;
    // R8 restart mid-stretch
    step(STR / 2); sup_ok = 3'b011;
    step(1); sup_ok = '1;
    step(STR - 1); smp(); chk("R8", hrst_n, 1'b0);
    step(1); smp(); chk("R8", hrst_n, 1'b1);
    // R4 short press: pulse after third edge, PUL cycles wide
    step(2); btn_n = 1'b0;
    step(5); btn_n = 1'b1;
    step(2); smp(); chk("R4", srst_n, 1'b1);
    step(1); smp(); chk("R4", srst_n, 1'b0); chk("R4", hrst_n, 1'b1);
    step(PUL - 1); smp(); chk("R4", srst_n, 1'b0);
    step(1); smp(); chk("R4", srst_n, 1'b1);
    // R3 / R6 long press
    step(3); btn_n = 1'b0;
    step(LONG + 1); smp(); chk("R3", hrst_n, 1'b1);
    step(1); smp(); chk("R3", hrst_n, 1'b0);
    step(10); btn_n = 1'b1;
    soft_seen = 0;
    for (int k = 0; k < STR + 3; k++) begin
      step(1); smp();
      if (!srst_n) soft_seen = 1;
      if (k == STR + 1) chk("R3", hrst_n, 1'b0);
      if (k == STR + 2) chk("R3", hrst_n, 1'b1);
    end
    chk("R6", soft_seen, 1'b0);
    // R7 fault during soft pulse
    step(2); btn_n = 1'b0;
    step(4); btn_n = 1'b1;
    step(4); smp(); chk("R7", srst_n, 1'b0);
    step(1); sup_ok = 3'b110; smp();
    chk("R7", srst_n, 1'b1); chk("R1", hrst_n, 1'b0);
    step(1); sup_ok = '1;
    step(STR + 2);
    // R9 press inside fault is ignored
    sup_ok = 3'b100;
    step(2); btn_n = 1'b0;
    step(10); btn_n = 1'b1;
    soft_seen = 0;
    for (int k = 0; k < 8; k++) begin
      step(1); smp();
      if (!srst_n) soft_seen = 1;
    end
    sup_ok = '1;
    for (int k = 0; k < STR + 4; k++) begin
      step(1); smp();
      if (!srst_n) soft_seen = 1;
    end
    chk("R9", soft_seen, 1'b0);
    chk("R9", hrst_n, 1'b1);
    // Random mix, model-checked every cycle
    for (int it = 0; it < 80; it++) begin
      int kind, d;
      kind = $urandom_range(0, 4);
      case (kind)
        0: begin d = $urandom_range(1, LONG - 1); btn_n = 1'b0; step(d); btn_n = 1'b1; end
        1: begin d = $urandom_range(LONG - 1, LONG + 15); btn_n = 1'b0; step(d); btn_n = 1'b1; end
        2: begin
             d = $urandom_range(1, 25);
             sup_ok = NS'($urandom_range(0, (1 << NS) - 2));
             step(d); sup_ok = '1;
           end
        3: begin
             btn_n = 1'b0; step($urandom_range(1, 20));
             sup_ok = NS'($urandom_range(0, (1 << NS) - 2));
             step($urandom_range(1, 6)); sup_ok = '1;
             step($urandom_range(1, 20)); btn_n = 1'b1;
           end
        default: ;
      endcase
      step($urandom_range(0, 30));
    end
    step(STR + PUL + 8);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule